// File: doc/BRIEF.md
# DDR Sample Output Formatter

This block sits between a 12-bit sampling core and the output pins. It accepts one sample per sample period, optionally replaces it with a generated test word, converts it to the chosen number format, and delays it through a fixed pipeline of 14 sample periods. It then drives the word in one of two output styles. In paired mode, six lanes each carry two bits per period, one bit in each half of the period. In parallel mode, all twelve lanes hold the full word for the whole period. The block also drives an output capture clock. In parallel mode, the edge position of that clock can be delayed in twelfths of a period.

The block runs from a single reference clock at twelve times the sample rate. An internal phase counter divides each sample period into phases 0 to 11. A sample period ends, and a new sample is captured, on the reference edge that leaves phase 11. Output style, clock placement and standby are also registered on that edge. They govern the whole of the following period.

Top module: `ddr_sample_fmt`

## Requirements
- R1: A sample captured at the end of period n appears on the outputs throughout period n+14, counting only periods in which conversion ran. Out of reset, the phase is 0, the pipeline holds zeros, `dout` is 0, paired mode is active and `clk_out` is 1.
- R2: With `fmt_offset`=0 a word passes unchanged as two's complement. With `fmt_offset`=1 its bit 11 is inverted, which gives offset binary. The format is taken per sample, at capture.
- R3: In paired mode (`mode_par`=0), lane `dout[k]` for k=0..5 carries bit 2k during phases 0 to 5 and bit 2k+1 during phases 6 to 11. `dout[11:6]` is 0.
- R4: In parallel mode (`mode_par`=1), `dout` holds the whole word for all twelve phases. `clk_out` is high exactly in phases (6+c) to (11+c) modulo 12, where c is `cke_sel`, so its rising edge is c twelfths later than phase 6.
- R5: In paired mode, `clk_out` is high in phases 0 to 5 for `cke_sel` codes 0, 1 and 2, so its edges line up with the data transitions. Code 3 moves both edges one phase earlier: high in phase 11 of the previous period and in phases 0 to 4.
- R6: `pat_sel` chooses the word that enters the formatter: 0 is the live sample, 1 is all zeros, 2 is all ones, and 3 is a ramp. The ramp counter starts at 0 after reset and advances by one at every capture that is not in standby.
- R7: While standby is registered for a period, `dout` is 0 and `clk_out` is 0. A capture edge with `stby`=1 neither shifts the pipeline nor advances the ramp.
- R8: Changes to `mode_par`, `cke_sel` or `stby` during a period have no effect on that period's outputs. Only their values at the capture edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twelve phases per sample period |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | 12 | Live sample, two's complement |
| pat_sel | input | 2 | Source select: live, zeros, ones, ramp |
| fmt_offset | input | 1 | 1 selects offset binary output |
| mode_par | input | 1 | 1 selects parallel output, 0 paired output |
| cke_sel | input | 2 | Output clock edge placement code |
| stby | input | 1 | Standby request |
| dout | output | 12 | Output data lanes |
| clk_out | output | 1 | Output capture clock |

## Verification
The assertions assume that configuration inputs are sampled only at the capture edge. They also assume that the phase counter is the only timing source, so output stability is checked between the phases where transitions are allowed. The bench holds every input steady from phase 0 of a period, except in the deliberate mid-period toggles used for R8, which always restore the value before the capture edge. The configuration sweep covers both output styles, all four clock codes and both number formats. A reference pipeline in the bench, advanced only on non-standby captures, supplies the expected word for every phase.

// File: rtl/ddr_fmt_pkg.sv
package ddr_fmt_pkg;

    localparam int SMP_W  = 12;
    localparam int LAT    = 14;
    localparam int PHASES = 12;

    typedef enum logic [1:0] {
        PAT_LIVE = 2'd0,
        PAT_ZERO = 2'd1,
        PAT_ONES = 2'd2,
        PAT_RAMP = 2'd3
    } pat_e;

    typedef struct packed {
        logic       par;
        logic [1:0] cke;
        logic       stby;
    } out_cfg_t;

    localparam out_cfg_t CFG_RESET = '{par: 1'b0, cke: 2'd0, stby: 1'b0};

endpackage

// File: rtl/ddr_phase_gen.sv
module ddr_phase_gen #(
    parameter int PHASES = ddr_fmt_pkg::PHASES,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] ph,
    output logic          tick
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    assign tick = (ph == LAST);

    always_ff @(posedge clk) begin
        if (rst)       ph <= '0;
        else if (tick) ph <= '0;
        else           ph <= ph + 1'b1;
    end
endmodule

// File: rtl/ddr_sample_pipe.sv
module ddr_sample_pipe
    import ddr_fmt_pkg::*;
#(
    parameter int W   = SMP_W,
    parameter int LAT = ddr_fmt_pkg::LAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         hold,
    input  logic [W-1:0] din,
    input  logic [1:0]   pat_sel,
    input  logic         offs,
    output logic [W-1:0] word
);
    logic [W-1:0] ramp;
    logic [W-1:0] raw;
    logic [W-1:0] fmtd;
    logic [W-1:0] pipe [LAT];

    always_comb begin
        case (pat_e'(pat_sel))
            PAT_ZERO: raw = '0;
            PAT_ONES: raw = '1;
            PAT_RAMP: raw = ramp;
            default:  raw = din;
        endcase
        fmtd = offs ? {~raw[W-1], raw[W-2:0]} : raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp <= '0;
            for (int i = 0; i < LAT; i++) pipe[i] <= '0;
        end else if (tick && !hold) begin
            ramp    <= ramp + 1'b1;
            pipe[0] <= fmtd;
            for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign word = pipe[LAT-1];
endmodule

// File: rtl/ddr_out_stage.sv
module ddr_out_stage
    import ddr_fmt_pkg::*;
#(
    parameter int W      = SMP_W,
    parameter int PHASES = ddr_fmt_pkg::PHASES,
    localparam int PW    = $clog2(PHASES),
    localparam int NL    = W / 2,
    localparam int HALF  = PHASES / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  out_cfg_t      cfg_in,
    input  logic [W-1:0]  word,
    input  logic [PW-1:0] ph,
    output out_cfg_t      cfg_q,
    output logic [W-1:0]  dout,
    output logic          clk_out
);
    localparam logic [PW:0] PHN   = (PW+1)'(PHASES);
    localparam logic [PW:0] HALFN = (PW+1)'(HALF);

    logic [NL-1:0] lanes;
    logic [PW:0]   ph_x;
    logic [PW:0]   late_ph;
    logic [PW:0]   early_ph;
    logic          first_half;

    always_ff @(posedge clk) begin
        if (rst)       cfg_q <= CFG_RESET;
        else if (tick) cfg_q <= cfg_in;
    end

    assign ph_x       = {1'b0, ph};
    assign first_half = (ph_x < HALFN);

    genvar k;
    generate
        for (k = 0; k < NL; k++) begin : g_lane
            assign lanes[k] = first_half ? word[2*k] : word[2*k+1];
        end
    endgenerate

    always_comb begin
        late_ph = ph_x + PHN - (PW+1)'(cfg_q.cke);
        if (late_ph >= PHN) late_ph = late_ph - PHN;
        early_ph = ph_x + 1'b1;
        if (early_ph >= PHN) early_ph = '0;
    end

    always_comb begin
        if (cfg_q.stby) begin
            dout    = '0;
            clk_out = 1'b0;
        end else if (cfg_q.par) begin
            dout    = word;
            clk_out = (late_ph >= HALFN);
        end else begin
            dout    = {{(W-NL){1'b0}}, lanes};
            clk_out = (cfg_q.cke == 2'd3) ? (early_ph < HALFN) : first_half;
        end
    end
endmodule

// File: rtl/ddr_sample_fmt.sv
module ddr_sample_fmt
    import ddr_fmt_pkg::*;
#(
    parameter int W      = SMP_W,
    parameter int LAT    = ddr_fmt_pkg::LAT,
    parameter int PHASES = ddr_fmt_pkg::PHASES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] smp_data,
    input  logic [1:0]   pat_sel,
    input  logic         fmt_offset,
    input  logic         mode_par,
    input  logic [1:0]   cke_sel,
    input  logic         stby,
    output logic [W-1:0] dout,
    output logic         clk_out
);
    localparam int PW = $clog2(PHASES);

    logic [PW-1:0] ph;
    logic          tick;
    logic [W-1:0]  word;
    out_cfg_t      cfg_in;
    out_cfg_t      cfg_q;

    assign cfg_in = '{par: mode_par, cke: cke_sel, stby: stby};

    ddr_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk (clk),
        .rst (rst),
        .ph  (ph),
        .tick(tick)
    );

    ddr_sample_pipe #(.W(W), .LAT(LAT)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .hold   (stby),
        .din    (smp_data),
        .pat_sel(pat_sel),
        .offs   (fmt_offset),
        .word   (word)
    );

    ddr_out_stage #(.W(W), .PHASES(PHASES)) u_out (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cfg_in (cfg_in),
        .word   (word),
        .ph     (ph),
        .cfg_q  (cfg_q),
        .dout   (dout),
        .clk_out(clk_out)
    );
endmodule

// File: rtl/ddr_fmt_chk.sv
module ddr_fmt_chk
    import ddr_fmt_pkg::*;
#(
    parameter int W      = SMP_W,
    parameter int PHASES = ddr_fmt_pkg::PHASES,
    localparam int PW    = $clog2(PHASES),
    localparam int HALF  = PHASES / 2
) (
    input logic          clk,
    input logic          rst,
    input logic [PW-1:0] ph,
    input out_cfg_t      cfg_q,
    input logic [W-1:0]  dout,
    input logic          clk_out
);
    a_r7_idle_outputs: assert property (@(posedge clk) disable iff (rst)
        cfg_q.stby |-> (dout == '0 && !clk_out));

    a_r3_upper_lanes_zero: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.par && !cfg_q.stby) |-> (dout[W-1:W/2] == '0));

    a_r3_half_period_hold: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.par && !cfg_q.stby && ph != 0 && int'(ph) != HALF) |-> $stable(dout));

    a_r4_word_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.par && !cfg_q.stby && ph != 0) |-> $stable(dout));

    a_r4_late_rise: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.par && !cfg_q.stby && ph != 0 && $rose(clk_out))
        |-> (int'(ph) == HALF + int'(cfg_q.cke)));

    a_r5_aligned_rise: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.par && !cfg_q.stby && cfg_q.cke != 2'd3 && $rose(clk_out)) |-> (ph == 0));
endmodule

bind ddr_sample_fmt ddr_fmt_chk #(.W(W), .PHASES(PHASES)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ph     (ph),
    .cfg_q  (cfg_q),
    .dout   (dout),
    .clk_out(clk_out)
);

// File: tb/ddr_sample_fmt_test.sv
module ddr_sample_fmt_test;
    localparam int CLK_P = 10;
    localparam int LATN  = 14;

    logic        clk = 0;
    logic        rst = 1;
    logic [11:0] smp_data = '0;
    logic [1:0]  pat_sel = '0;
    logic        fmt_offset = 0;
    logic        mode_par = 0;
    logic [1:0]  cke_sel = '0;
    logic        stby = 0;
    logic [11:0] dout;
    logic        clk_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [11:0] q [LATN];
    logic [11:0] ramp_m = '0;
    logic        m_par = 0;
    logic [1:0]  m_cke = '0;
    logic        m_stby = 0;
    int          seq = 0;

    always #(CLK_P/2) clk = ~clk;

    ddr_sample_fmt uut (
        .clk(clk), .rst(rst), .smp_data(smp_data), .pat_sel(pat_sel),
        .fmt_offset(fmt_offset), .mode_par(mode_par), .cke_sel(cke_sel),
        .stby(stby), .dout(dout), .clk_out(clk_out)
    );

    task automatic check(input int ph, input string tag);
        logic [11:0] w, ed;
        logic ec;
        w = q[LATN-1];
        if (m_stby) begin
            ed = '0; ec = 0;
        end else if (m_par) begin
            ed = w;
            ec = (((ph - int'(m_cke) + 12) % 12) >= 6);
        end else begin
            ed = '0;
            for (int k = 0; k < 6; k++) ed[k] = (ph < 6) ? w[2*k] : w[2*k+1];
            ec = (m_cke == 2'd3) ? (((ph + 1) % 12) < 6) : (ph < 6);
        end
        n_tests++;
        if (dout !== ed || clk_out !== ec) begin
            n_fail++;
            $display("FAIL %s ph=%0d dout=%h exp %h clk_out=%b exp %b", tag, ph, dout, ed, clk_out, ec);
        end
    endtask

    // Starts at a falling edge in phase 0; ends at the falling edge in phase 0 of the next period.
    task automatic run_period(input logic [1:0] pat, input logic offs, input logic par,
                              input logic [1:0] cke, input logic sb, input bit glitch,
                              input string tag);
        logic [11:0] raw, fm;
        for (int p = 0; p < 12; p++) begin
            check(p, tag);
            if (p == 0) begin
                smp_data = 12'((seq * 1237 + 91) & 12'hFFF);
                pat_sel = pat; fmt_offset = offs; mode_par = par; cke_sel = cke; stby = sb;
                rst = 0;
            end
            if (glitch && p == 3) begin mode_par = ~par; cke_sel = ~cke; stby = ~sb; end
            if (glitch && p == 8) begin mode_par = par; cke_sel = cke; stby = sb; end
            @(negedge clk);
        end
        case (pat)
            2'd1: raw = '0;
            2'd2: raw = '1;
            2'd3: raw = ramp_m;
            default: raw = smp_data;
        endcase
        fm = offs ? (raw ^ 12'h800) : raw;
        if (!sb) begin
            for (int i = LATN-1; i > 0; i--) q[i] = q[i-1];
            q[0] = fm;
            ramp_m = ramp_m + 1'b1;
        end
        m_par = par; m_cke = cke; m_stby = sb;
        seq++;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LATN; i++) q[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, checked while reset is still high
        n_tests++;
        if (dout !== 12'h000 || clk_out !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 reset dout=%h exp 000 clk_out=%b exp 1", dout, clk_out);
        end
        // R1, R3: latency and paired lanes with live samples
        for (int i = 0; i < 20; i++) run_period(2'd0, 0, 0, 2'd0, 0, 0, "R1_R3");
        // R2, R4, R5: sweep of style, clock code and format
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 4; c++)
                for (int f = 0; f < 2; f++)
                    for (int r = 0; r < 3; r++)
                        run_period(2'd0, f[0], m[0], c[1:0], 0, 0,
                                   m == 1 ? "R2_R4" : "R2_R5");
        // R6: test patterns in both formats
        for (int p = 1; p < 4; p++)
            for (int r = 0; r < 6; r++)
                run_period(p[1:0], r[0], r[1], 2'd1, 0, 0, "R6");
        for (int r = 0; r < 16; r++) run_period(2'd3, 0, 1, 2'd2, 0, 0, "R6");
        // R7: standby holds the pipeline and idles outputs
        for (int r = 0; r < 4; r++) run_period(2'd3, 0, 1, 2'd0, 1, 0, "R7");
        for (int r = 0; r < 16; r++) run_period(2'd0, 0, r[2], 2'd0, 0, 0, "R7");
        // R8: mid-period configuration changes are ignored
        for (int r = 0; r < 8; r++) run_period(2'd0, r[0], r[1], 2'(r), 0, 1, "R8");
        for (int r = 0; r < 16; r++) run_period(2'd0, 0, 0, 2'd3, 0, 0, "R8");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule